// File: doc/BRIEF.md
# USB Token Packet Bit Serializer

This block produces the pre-stuffing NRZ bit sequence of a USB token packet, one bit per clock. A caller presents a 4-bit packet identifier and either a 7-bit device address with a 4-bit endpoint number or an 11-bit frame number, and pulses `start`. The block latches these values. It then sends, in order, a sync pattern, the identifier, its inverted check nibble, the 11-bit payload, a 5-bit CRC over that payload, and an end-of-packet marker. Each bit is presented on a 2-bit line-state code.

The identifier value 0101 selects the frame number as the payload. Every other identifier selects the address and endpoint pair. The CRC uses the generator x^5 + x^2 + 1 and is computed serially as the payload bits leave the block. NRZI encoding, bit stuffing and the line drivers follow this block and are not part of it.

Top module: `usb_token_serializer`

## Requirements
- R1: While reset is asserted, and whenever no packet is in progress, `busy` is 0 and `line_state` is 01 (data 1, the idle J level). Line-state codes are 00 for data 0, 01 for data 1 and 10 for SE0.
- R2: When `start` is high and `busy` is low at a rising edge, the inputs are captured. The first packet bit appears after that edge, and `busy` stays high for exactly 35 cycles.
- R3: The first 8 bits are the sync pattern 0,0,0,0,0,0,0,1.
- R4: The next 4 bits are the identifier, least significant bit first. The 4 bits after them are the bitwise inverse of the identifier, also least significant bit first.
- R5: For an identifier other than 0101, the 11 payload bits are the 7-bit address, LSB first, followed by the 4-bit endpoint, LSB first. `frame_num` has no effect.
- R6: For identifier 0101, the 11 payload bits are `frame_num`, LSB first. `dev_addr` and `ep_num` have no effect.
- R7: The 5 bits after the payload are the CRC. The register is seeded with all ones, updated with the generator x^5+x^2+1 over the 11 payload bits only, and then inverted. It is sent most significant bit first.
- R8: The packet ends with two SE0 bit times followed by one data-1 (J) bit time. `busy` falls right after the J bit.
- R9: A `start` pulse, or any change on the data inputs, while `busy` is high does not alter the packet in progress.
- R10: A `start` in the first cycle after `busy` falls is accepted, so packets can be sent back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a packet when idle |
| pid | input | 4 | Token packet identifier |
| dev_addr | input | 7 | Device address (non-frame tokens) |
| ep_num | input | 4 | Endpoint number (non-frame tokens) |
| frame_num | input | 11 | Frame number (identifier 0101) |
| line_state | output | 2 | Line-state code of the current bit |
| busy | output | 1 | High while packet bits are being sent |

## Verification
A bit counter that is off by one shifts a whole field. The error shows at once as a wrong sync length, or as SE0 appearing early or late, and `busy` runs a cycle too long or too short. A corrupted CRC register shows only in the five bits after the payload, about 27 cycles after start. For that reason every packet is compared bit for bit against the known-good sequences, which include address, endpoint and frame tokens. A wrong payload selection shows when the ignored fields carry different values, so the bench drives garbage on them and changes the inputs while a packet is in progress.

// File: rtl/usb_tok_pkg.sv
package usb_tok_pkg;

    // Line-state code presented per bit time
    typedef enum logic [1:0] {
        LS_D0  = 2'b00,
        LS_D1  = 2'b01,
        LS_SE0 = 2'b10
    } line_e;

    // Packet segment currently being sent
    typedef enum logic [2:0] {
        SEG_SYNC = 3'd0,
        SEG_PID  = 3'd1,
        SEG_CHK  = 3'd2,
        SEG_DATA = 3'd3,
        SEG_CRC  = 3'd4,
        SEG_SE0  = 3'd5,
        SEG_J    = 3'd6
    } seg_e;

endpackage

// File: rtl/usb_crc5_step.sv
// One serial step of the token CRC: shift the register left and fold in the
// generator when the incoming bit differs from the register MSB.
module usb_crc5_step #(
    parameter int               CRC_W    = 5,
    parameter logic [CRC_W-1:0] CRC_POLY = 5'b00101
) (
    input  logic [CRC_W-1:0] crc_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = bit_i ^ crc_i[CRC_W-1];
        crc_o = {crc_i[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
endmodule

// File: rtl/usb_tok_seg_decode.sv
// Maps the packet bit index onto the segment and the offset within it.
module usb_tok_seg_decode
    import usb_tok_pkg::*;
#(
    parameter int SYNC_W   = 8,
    parameter int PID_W    = 4,
    parameter int PAY_W    = 11,
    parameter int CRC_W    = 5,
    parameter int SE0_BITS = 2,
    parameter int IDX_W    = 6
) (
    input  logic [IDX_W-1:0] idx,
    output seg_e             seg,
    output logic [IDX_W-1:0] off
);
    localparam int B_PID  = SYNC_W;
    localparam int B_CHK  = B_PID + PID_W;
    localparam int B_DATA = B_CHK + PID_W;
    localparam int B_CRC  = B_DATA + PAY_W;
    localparam int B_SE0  = B_CRC + CRC_W;
    localparam int B_J    = B_SE0 + SE0_BITS;

    int pos;
    int base;

    always_comb begin
        pos = int'(idx);
        if (pos < B_PID) begin
            seg  = SEG_SYNC;
            base = 0;
        end else if (pos < B_CHK) begin
            seg  = SEG_PID;
            base = B_PID;
        end else if (pos < B_DATA) begin
            seg  = SEG_CHK;
            base = B_CHK;
        end else if (pos < B_CRC) begin
            seg  = SEG_DATA;
            base = B_DATA;
        end else if (pos < B_SE0) begin
            seg  = SEG_CRC;
            base = B_CRC;
        end else if (pos < B_J) begin
            seg  = SEG_SE0;
            base = B_SE0;
        end else begin
            seg  = SEG_J;
            base = B_J;
        end
        off = IDX_W'(pos - base);
    end
endmodule

// File: rtl/usb_tok_bit_sel.sv
// Picks the line-state code of the current bit from the latched fields.
module usb_tok_bit_sel
    import usb_tok_pkg::*;
#(
    parameter int SYNC_W = 8,
    parameter int PID_W  = 4,
    parameter int PAY_W  = 11,
    parameter int CRC_W  = 5,
    parameter int IDX_W  = 6
) (
    input  seg_e             seg,
    input  logic [IDX_W-1:0] off,
    input  logic [PID_W-1:0] pid,
    input  logic [PAY_W-1:0] pay,
    input  logic [CRC_W-1:0] crc,
    output line_e            line
);
    localparam int PID_IW = $clog2(PID_W);
    localparam int PAY_IW = $clog2(PAY_W);
    localparam int CRC_IW = $clog2(CRC_W);

    logic [PID_IW-1:0] off_pid;
    logic [PAY_IW-1:0] off_pay;
    logic [CRC_IW-1:0] off_crc;
    logic              bit_v;

    assign off_pid = off[PID_IW-1:0];
    assign off_pay = off[PAY_IW-1:0];
    // CRC leaves MSB first, so count down from the top bit
    assign off_crc = CRC_IW'(CRC_W - 1) - off[CRC_IW-1:0];

    always_comb begin
        bit_v = 1'b1;
        line  = LS_D1;
        unique case (seg)
            SEG_SYNC: bit_v = (off == IDX_W'(SYNC_W - 1));
            SEG_PID:  bit_v = pid[off_pid];
            SEG_CHK:  bit_v = ~pid[off_pid];
            SEG_DATA: bit_v = pay[off_pay];
            SEG_CRC:  bit_v = ~crc[off_crc];
            default:  bit_v = 1'b1;
        endcase
        if (seg == SEG_SE0) line = LS_SE0;
        else                line = bit_v ? LS_D1 : LS_D0;
    end
endmodule

// File: rtl/usb_token_serializer.sv
module usb_token_serializer
    import usb_tok_pkg::*;
#(
    parameter int               SYNC_W   = 8,
    parameter int               PID_W    = 4,
    parameter int               ADDR_W   = 7,
    parameter int               EP_W     = 4,
    parameter int               CRC_W    = 5,
    parameter logic [CRC_W-1:0] CRC_POLY = 5'b00101,
    parameter int               SE0_BITS = 2,
    parameter logic [PID_W-1:0] SOF_PID  = 4'b0101
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [PID_W-1:0]       pid,
    input  logic [ADDR_W-1:0]      dev_addr,
    input  logic [EP_W-1:0]        ep_num,
    input  logic [ADDR_W+EP_W-1:0] frame_num,
    output logic [1:0]             line_state,
    output logic                   busy
);
    localparam int PAY_W    = ADDR_W + EP_W;
    localparam int PKT_BITS = SYNC_W + 2 * PID_W + PAY_W + CRC_W + SE0_BITS + 1;
    localparam int IDX_W    = $clog2(PKT_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BITS - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [PID_W-1:0] pid;
        logic [PAY_W-1:0] pay;
        logic [CRC_W-1:0] crc;
    } st_t;

    st_t        st_d, st_q;
    seg_e       seg;
    logic [IDX_W-1:0] seg_off;
    line_e      cur_line;
    logic [CRC_W-1:0] crc_next;

    usb_tok_seg_decode #(
        .SYNC_W(SYNC_W), .PID_W(PID_W), .PAY_W(PAY_W),
        .CRC_W(CRC_W), .SE0_BITS(SE0_BITS), .IDX_W(IDX_W)
    ) u_seg (
        .idx(st_q.idx),
        .seg(seg),
        .off(seg_off)
    );

    usb_tok_bit_sel #(
        .SYNC_W(SYNC_W), .PID_W(PID_W), .PAY_W(PAY_W),
        .CRC_W(CRC_W), .IDX_W(IDX_W)
    ) u_sel (
        .seg (seg),
        .off (seg_off),
        .pid (st_q.pid),
        .pay (st_q.pay),
        .crc (st_q.crc),
        .line(cur_line)
    );

    usb_crc5_step #(
        .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)
    ) u_crc (
        .crc_i(st_q.crc),
        .bit_i(cur_line == LS_D1),
        .crc_o(crc_next)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.pid  = pid;
                st_d.pay  = (pid == SOF_PID) ? frame_num : {ep_num, dev_addr};
                st_d.crc  = '1;
            end
        end else begin
            if (seg == SEG_DATA) st_d.crc = crc_next;
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = st_q.busy;
    assign line_state = st_q.busy ? cur_line : LS_D1;

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7
    crc_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (st_q.crc == '1));

    // R8
    eop_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LS_SE0 && $past(line_state) == LS_SE0) |=> (line_state == LS_D1));

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(line_state) == LS_D1 && $past(line_state, 2) == LS_SE0));

    // R9
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(st_q.pid) && $stable(st_q.pay)));

    // R3
    no_early_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seg != SEG_SE0) |-> (line_state != LS_SE0));

endmodule

// File: tb/tb_usb_token_serializer.sv
module tb_usb_token_serializer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  pid = '0;
    logic [6:0]  dev_addr = '0;
    logic [3:0]  ep_num = '0;
    logic [10:0] frame_num = '0;
    logic [1:0]  line_state;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam int PKT = 35;

    always #4 clk = ~clk;

    usb_token_serializer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pid(pid),
        .dev_addr(dev_addr), .ep_num(ep_num), .frame_num(frame_num),
        .line_state(line_state), .busy(busy)
    );

    typedef struct packed {
        logic [3:0]  p;
        logic [6:0]  a;
        logic [3:0]  e;
        logic [10:0] f;
        logic [31:0] x;
    } vec_t;

    localparam logic [7:0] SY = 8'b00000001;

    localparam vec_t VECS [5] = '{
        '{4'hD, 7'h15, 4'hE, 11'h7FF, {SY, 4'b1011, 4'b0100, 11'b10101000111, 5'b10111}},
        '{4'h1, 7'h3A, 4'hA, 11'h2AA, {SY, 4'b1000, 4'b0111, 11'b01011100101, 5'b11100}},
        '{4'h9, 7'h70, 4'h4, 11'h555, {SY, 4'b1001, 4'b0110, 11'b00001110010, 5'b01110}},
        '{4'h5, 7'h7F, 4'hF, 11'h710, {SY, 4'b1010, 4'b0101, 11'b00001000111, 5'b10100}},
        '{4'h5, 7'h55, 4'h3, 11'h001, {SY, 4'b1010, 4'b0101, 11'b10000000000, 5'b10111}}
    };

    task automatic chk(input bit ok, input string req, input logic [69:0] act, input logic [69:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [3:0] p, input logic [10:0] pay);
        logic [31:0] e;
        logic [4:0]  c;
        logic        fb;
        int          n;
        e = '0;
        n = 31;
        for (int i = 0; i < 8; i++) begin e[n] = (i == 7); n = n - 1; end
        for (int i = 0; i < 4; i++) begin e[n] = p[i]; n = n - 1; end
        for (int i = 0; i < 4; i++) begin e[n] = ~p[i]; n = n - 1; end
        c = 5'h1F;
        for (int i = 0; i < 11; i++) begin
            e[n] = pay[i];
            n = n - 1;
            fb = pay[i] ^ c[4];
            c = {c[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
        end
        for (int i = 0; i < 5; i++) begin e[n] = ~c[4 - i]; n = n - 1; end
        return e;
    endfunction

    // Called at a negedge with the block idle; returns at the negedge after
    // the J bit. Mid-packet it drives a new start and scrambled inputs (R9).
    task automatic run_pkt(input logic [3:0] p, input logic [6:0] a, input logic [3:0] e,
                           input logic [10:0] f, input logic [31:0] x, input string tag);
        logic [69:0] act, exp;
        int          busy_cnt;
        pid = p; dev_addr = a; ep_num = e; frame_num = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_cnt = 0;
        for (int k = 0; k < PKT; k++) begin
            act[69 - 2*k -: 2] = line_state;
            if (k < 32)      exp[69 - 2*k -: 2] = x[31 - k] ? 2'b01 : 2'b00;
            else if (k < 34) exp[69 - 2*k -: 2] = 2'b10;
            else             exp[69 - 2*k -: 2] = 2'b01;
            if (busy) busy_cnt++;
            if (k == 10) begin
                start = 1'b1; pid = ~p; dev_addr = ~a; ep_num = ~e; frame_num = ~f;
            end
            if (k == 11) start = 1'b0;
            @(negedge clk);
        end
        // R3 R4 R5 R6 R7 R8 R9: whole bit stream
        chk(act == exp, {"R3-stream ", tag}, act, exp);
        // R2: busy for exactly 35 bit times
        chk(busy_cnt == PKT, {"R2 busy length ", tag}, 70'(busy_cnt), 70'(PKT));
        // R8: busy falls after J, line back to idle
        chk(!busy && line_state == 2'b01, {"R8 idle after EOP ", tag},
            70'({busy, line_state}), 70'(3'b001));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: state during reset
        repeat (3) @(negedge clk);
        chk(!busy && line_state == 2'b01, "R1 reset", 70'({busy, line_state}), 70'(3'b001));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && line_state == 2'b01, "R1 idle", 70'({busy, line_state}), 70'(3'b001));

        // Table walk; packets run back to back (R10)
        for (int v = 0; v < 5; v++)
            run_pkt(VECS[v].p, VECS[v].a, VECS[v].e, VECS[v].f, VECS[v].x,
                    $sformatf("R10 vec%0d", v));

        // R5: extreme address/endpoint values, frame ignored
        run_pkt(4'h1, 7'h7F, 4'hF, 11'h000, model(4'h1, {4'hF, 7'h7F}), "R5 ones");
        run_pkt(4'h9, 7'h00, 4'h0, 11'h7FF, model(4'h9, 11'h000), "R5 zeros");
        // R6: frame extremes, address/endpoint ignored
        run_pkt(4'h5, 7'h2A, 4'h5, 11'h7FF, model(4'h5, 11'h7FF), "R6 max frame");
        // R7: CRC over a payload with alternating bits
        run_pkt(4'hD, 7'h55, 4'hA, 11'h0F0, model(4'hD, {4'hA, 7'h55}), "R7 alt");

        // R1: reset in the middle of a packet returns to idle
        @(negedge clk);
        pid = 4'hD; dev_addr = 7'h15; ep_num = 4'hE; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && line_state == 2'b01, "R1 mid-packet reset",
            70'({busy, line_state}), 70'(3'b001));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && line_state == 2'b01, "R1 idle after reset",
            70'({busy, line_state}), 70'(3'b001));
        run_pkt(VECS[0].p, VECS[0].a, VECS[0].e, VECS[0].f, VECS[0].x, "R2 recovery");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule